// File: doc/BRIEF.md
# Integer Compare Flag Generator

This unit compares two signed integer operands by subtracting the second from the first. From that difference it builds four condition flags: negative, zero, carry and overflow. It returns them as one packed 32-bit status word that a host processor reads back. A width-select input picks the operand width. In narrow mode only the low 32-bit halves of the two 64-bit source registers take part. In wide mode all 64 bits of each register are compared.

The host presents the operands together with a one-cycle valid strobe. The unit captures the compare result in a register and raises its own valid pulse on the following cycle. The status word keeps its value until the next strobe. The unit only forms the word; whatever consumes it decides what to do with the flags.

Top module: `icmp_flag_unit`

## Requirements
- R1: The status word carries the flags at fixed positions: negative in bit 31, zero in bit 30, carry in bit 29, overflow in bit 28.
- R2: Bits 27 down to 0 of the status word are always zero.
- R3: With `wideMode` low, only bits 31:0 of each operand are compared and the upper halves have no effect on the result. With `wideMode` high, all 64 bits are compared.
- R4: The difference is `opA - opB` at the selected width. The zero flag is set when this difference is zero. The negative flag equals the top bit of the difference at that width.
- R5: Let a, b and r be the top bits, at the selected width, of the first operand, the second operand and the difference. The carry flag is set when (a=1 and b=0), or (a=1 and r=0), or (b=0 and r=0). This is the same as the first operand being unsigned-greater-or-equal to the second.
- R6: The overflow flag is set in two cases: a=1, b=0 and r=0; or a=0, b=1 and r=1. It is clear otherwise.
- R7: `outValid` is high in exactly the cycle after each cycle in which `inValid` is high, and low otherwise.
- R8: Operands are sampled only while `inValid` is high. In every other cycle the status word holds its previous value, whatever the operand and width inputs do.
- R9: While `rstN` is low and right after it is released, `outValid` is 0 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand strobe; captures a compare |
| wideMode | input | 1 | 1: compare 64 bits; 0: compare low 32 bits |
| opA | input | 64 | First operand (minuend) |
| opB | input | 64 | Second operand (subtrahend) |
| outValid | output | 1 | One-cycle pulse, status word is fresh |
| flagWord | output | 32 | Packed flags N,Z,C,V in bits 31..28, zeros below |

## Verification
The assertions check the timing on every cycle: the valid pulse comes one cycle after each strobe and never without one, and the word holds between strobes. They also check that the low 28 bits stay zero. On top of that, they check the flag relations that must always hold: equal operands give zero and carry with no overflow, and zero never comes with negative. Only the bench's scenarios can show whether the carry and overflow values are correct for particular operand pairs. Examples are the most negative value minus one and the largest positive value minus minus-one, at both widths. The scenarios also show that garbage in the upper halves does not change a narrow compare.

// File: rtl/icmp_flag_pkg.sv
package icmp_flag_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cmpFlags_t;

  typedef struct packed {
    logic capture;
    logic useWide;
  } cmpCtrl_t;

endpackage

// File: rtl/icmp_flag_core.sv
module icmp_flag_core #(
  parameter int W = 32
) (
  input  logic [W-1:0]                 a,
  input  logic [W-1:0]                 b,
  output icmp_flag_pkg::cmpFlags_t     flags
);
  localparam int MSB = W - 1;

  logic [W-1:0] diff;
  logic         signA;
  logic         signB;
  logic         signR;

  always_comb begin
    diff  = a - b;
    signA = a[MSB];
    signB = b[MSB];
    signR = diff[MSB];
    flags.n = signR;
    flags.z = (diff == '0);
    flags.c = (signA & ~signB) | (signA & ~signR) | (~signB & ~signR);
    flags.v = (signA & ~signB & ~signR) | (~signA & signB & signR);
  end
endmodule

// File: rtl/icmp_flag_ctrl.sv
module icmp_flag_ctrl (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       wideMode,
  output icmp_flag_pkg::cmpCtrl_t    ctrl,
  output logic                       outValid
);
  always_comb begin
    ctrl.capture = inValid;
    ctrl.useWide = wideMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/icmp_flag_dp.sv
module icmp_flag_dp #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int WORD_W   = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  icmp_flag_pkg::cmpCtrl_t    ctrl,
  input  logic [DATA_W-1:0]          opA,
  input  logic [DATA_W-1:0]          opB,
  output logic [WORD_W-1:0]          flagWord
);
  import icmp_flag_pkg::*;

  localparam int LANES  = 2;
  localparam int FLAG_W = $bits(cmpFlags_t);
  localparam int PAD_W  = WORD_W - FLAG_W;

  cmpFlags_t laneFlags [LANES];
  cmpFlags_t selFlags;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int LW = (g == 0) ? NARROW_W : DATA_W;
    icmp_flag_core #(.W(LW)) uCore (
      .a     (opA[LW-1:0]),
      .b     (opB[LW-1:0]),
      .flags (laneFlags[g])
    );
  end

  always_comb selFlags = ctrl.useWide ? laneFlags[1] : laneFlags[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagWord <= '0;
    else if (ctrl.capture) flagWord <= {selFlags, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/icmp_flag_unit.sv
module icmp_flag_unit #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] flagWord
);
  icmp_flag_pkg::cmpCtrl_t ctrl;

  icmp_flag_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wideMode (wideMode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  icmp_flag_dp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .WORD_W(WORD_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .flagWord (flagWord)
  );
endmodule

// File: rtl/icmp_flag_unit_chk.sv
module icmp_flag_unit_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int WORD_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              wideMode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              outValid,
  input logic [WORD_W-1:0] flagWord
);
  localparam int NB = WORD_W - 1;
  localparam int ZB = WORD_W - 2;
  localparam int CB = WORD_W - 3;
  localparam int VB = WORD_W - 4;

  logic sameOps;
  always_comb sameOps = wideMode ? (opA == opB) : (opA[NARROW_W-1:0] == opB[NARROW_W-1:0]);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R7
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(flagWord)); // R8
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[VB-1:0] == '0); // R2
  AST_EQUAL_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sameOps) |=> flagWord[ZB]); // R4
  AST_ZERO_FLAG_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagWord[ZB]) |-> (flagWord[CB] && !flagWord[VB] && !flagWord[NB])); // R5
endmodule

bind icmp_flag_unit icmp_flag_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .wideMode(wideMode),
  .opA(opA), .opB(opB), .outValid(outValid), .flagWord(flagWord)
);

// File: tb/icmp_flag_unit_test.sv
`timescale 1ns/1ps
module icmp_flag_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        wideMode = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [31:0] flagWord;

  int    testsRun = 0;
  int    testsFailed = 0;
  string curTag = "R9";
  bit    cmpOn = 1'b0;
  bit    finished = 1'b0;

  logic        expValid;
  logic [31:0] expWord;

  always #2.5 clk = ~clk;

  icmp_flag_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wideMode(wideMode),
    .opA(opA), .opB(opB), .outValid(outValid), .flagWord(flagWord)
  );

  function automatic logic [31:0] refWord(logic [63:0] a, logic [63:0] b, logic wide);
    logic [63:0] mask, ua, ub, d;
    int top;
    logic n, z, c, v, sa, sb;
    mask = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    top  = wide ? 63 : 31;
    ua = a & mask;
    ub = b & mask;
    d  = (ua - ub) & mask;
    sa = ua[top];
    sb = ub[top];
    n  = d[top];
    z  = (d == 64'd0);
    c  = (ua >= ub);
    v  = (sa != sb) && (n != sa);
    return {n, z, c, v, 28'd0};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expWord  <= '0;
    end else begin
      expValid <= inValid;
      if (inValid) expWord <= refWord(opA, opB, wideMode);
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      check("R7 valid", {63'd0, outValid}, {63'd0, expValid});
      check(curTag, {32'd0, flagWord}, {32'd0, expWord});
    end
  end

  task automatic issue(logic [63:0] a, logic [63:0] b, logic w);
    @(negedge clk);
    opA = a; opB = b; wideMode = w; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic directed(string tag, logic [63:0] a, logic [63:0] b, logic w, logic [31:0] exp);
    curTag = tag;
    issue(a, b, w);
    check(tag, {32'd0, flagWord}, {32'd0, exp});
    check({tag, " pulse"}, {63'd0, outValid}, 64'd1);
  endtask

  initial begin
    #(200000 * 5);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", {63'd0, outValid}, 64'd0);
    check("R9 reset word", {32'd0, flagWord}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after release", {32'd0, flagWord}, 64'd0);
    cmpOn = 1'b1;

    // R1 R4 R5: equal operands, wide -> Z and C only
    directed("R4 equal wide", 64'd5, 64'd5, 1'b1, 32'h6000_0000);
    directed("R4 equal narrow", 64'hAAAA_0000_0000_0009, 64'h5555_0000_0000_0009, 1'b0, 32'h6000_0000);
    // R6: most negative minus one -> C and V
    directed("R6 minneg-1 wide", 64'h8000_0000_0000_0000, 64'd1, 1'b1, 32'h3000_0000);
    directed("R6 minneg-1 narrow", 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_0000_0001, 1'b0, 32'h3000_0000);
    // R3: same operands compared wide give a different word
    directed("R3 wide uses upper", 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_0000_0001, 1'b1, 32'hA000_0000);
    // R6: max positive minus minus-one -> N and V
    directed("R6 maxpos-m1 wide", 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 32'h9000_0000);
    directed("R6 maxpos-m1 narrow", 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 32'h9000_0000);
    // R5: small minus larger -> negative, no carry
    directed("R5 3-7 wide", 64'd3, 64'd7, 1'b1, 32'h8000_0000);
    directed("R1 layout 7-3", 64'd7, 64'd3, 1'b0, 32'h2000_0000);

    // R8: idle cycles with changing inputs leave the word unchanged
    curTag = "R8 hold";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opA = {$urandom, $urandom}; opB = {$urandom, $urandom}; wideMode = i[0];
      check("R8 hold word", {32'd0, flagWord}, 64'h0000_0000_2000_0000);
      check("R7 no pulse", {63'd0, outValid}, 64'd0);
    end

    // R2 R3 R4 R5 R6 R7: back-to-back and spaced random compares
    curTag = "R5 random";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      opA = {$urandom, $urandom};
      opB = (i % 7 == 0) ? opA : {$urandom, $urandom};
      if (i % 5 == 1) opB[31:0] = opA[31:0];
      wideMode = $urandom_range(0, 1);
      inValid  = ($urandom_range(0, 3) != 0);
      check("R2 low bits", {32'd0, 4'd0, flagWord[27:0]}, 64'd0);
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule